// File: doc/BRIEF.md
# USB Host Link-State Sequencer

This block sits on the downstream-port side of a USB host controller. It times the bus-control signalling that surrounds normal packet traffic: bus reset, suspend, and resume. It tells the line driver which condition to place on the wires (J/idle, K, SE0, or a low-speed end-of-packet). It also produces a 1 ms frame marker tick for the start-of-frame generator, a suspended status, and a flag that tells the transaction engine when it may start packets.

All durations come from a microsecond timebase. A prescaler derives that timebase from the system clock, and the prescaler restarts whenever the sequencer changes state, so every timed phase lasts an exact whole number of system clocks. A bus-reset request wins over everything else and restarts the reset timer even if a reset is already running. A resume can come from a local request or from a remote device driving K on the bus for at least 2.5 µs. Either way the host drives K itself for the full resume time, closes with an end-of-packet, and then holds a quiet period before traffic may resume. If software does not enable frame markers within one frame time of the end of resume, the link falls back into suspend.

Top module: `usb_host_link_seq`

## Requirements
- R1: After the asynchronous reset the block reports suspended=1, line code J, traffic permitted=0 and frame tick=0. The line codes are J=2'b00, K=2'b01, SE0=2'b10, EOP=2'b11.
- R2: A bus-reset request makes the line code SE0 from the next cycle. SE0 lasts exactly RESET_MS*US_PER_MS*CLK_PER_US cycles.
- R3: A bus-reset request has priority over a resume request and over remote wake detection. A new bus-reset request during an ongoing reset restarts the full reset duration from that cycle.
- R4: After reset SE0 the line code is J and traffic stays blocked for exactly QUIET_MS*US_PER_MS*CLK_PER_US cycles. The block then enters idle if the start-of-frame enable is high at that point, and suspend otherwise.
- R5: In idle, frame tick pulses high for one cycle every US_PER_MS*CLK_PER_US cycles. The first pulse comes that many cycles after idle is entered.
- R6: In idle, a low start-of-frame enable puts the block into suspend on the next cycle, with traffic permitted low. In suspend, raising the start-of-frame enable alone does not leave suspend.
- R7: A resume request while suspended clears suspended on the next cycle and drives line code K for exactly RESUME_MS*US_PER_MS*CLK_PER_US cycles. Outside suspend a resume request is ignored.
- R8: Resume K is followed by line code EOP for exactly EOP_US*CLK_PER_US cycles. Then comes line code J with traffic blocked for QUIET_MS*US_PER_MS*CLK_PER_US cycles.
- R9: If the start-of-frame enable is never high during the first US_PER_MS*CLK_PER_US cycles of the post-resume quiet period, the block returns to suspend at the end of that window. Otherwise the quiet period runs to its end.
- R10: While suspended, remote-K high for ceil(2.5*CLK_PER_US) consecutive cycles starts host resume K on the next cycle, with the same full K duration as R7. Shorter bursts leave the block suspended.
- R11: Traffic permitted is high only in idle, where the line code is J and suspended is low. In idle, resume requests and remote-K have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_req_i | input | 1 | Request to drive bus reset (pulse) |
| resume_req_i | input | 1 | Request to leave suspend by driving resume |
| sof_en_i | input | 1 | Start-of-frame (frame marker) enable |
| remote_k_i | input | 1 | Receiver sees K on the bus |
| line_o | output | 2 | Line condition command: J, K, SE0 or EOP |
| frame_tick_o | output | 1 | One-cycle pulse per frame while idle |
| suspended_o | output | 1 | Link is in suspend |
| traffic_ok_o | output | 1 | Transaction engine may start packets |

## Verification
Every output is decoded from a registered state, so a request sampled at a clock edge shows its effect on the outputs right after that same edge. Each timed phase ends exactly its stated number of cycles after the edge that entered it. The frame tick is registered one stage later and appears exactly one frame period after idle entry. The remote-K detector acts on the edge where the burst reaches its required length. The bench drives inputs and samples outputs on falling edges. It checks each phase boundary one cycle before and exactly at the computed cycle, and it counts frame ticks over windows that are exact multiples of the frame period.

// File: rtl/usb_link_pkg.sv
package usb_link_pkg;

  typedef enum logic [1:0] {
    LINE_J   = 2'd0,
    LINE_K   = 2'd1,
    LINE_SE0 = 2'd2,
    LINE_EOP = 2'd3
  } line_e;

  typedef enum logic [2:0] {
    ST_SUSP      = 3'd0,
    ST_IDLE      = 3'd1,
    ST_RST       = 3'd2,
    ST_RST_QUIET = 3'd3,
    ST_RSM       = 3'd4,
    ST_RSM_EOP   = 3'd5,
    ST_RSM_QUIET = 3'd6
  } link_st_e;

endpackage

// File: rtl/usb_us_prescaler.sv
module usb_us_prescaler #(
  parameter int unsigned CLK_PER_US = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic us_tick_o
);

  localparam int unsigned CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    us_tick_o = (cnt_q == LAST);
    if (restart_i || us_tick_o) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  generate
    if (CLK_PER_US > 1) begin : g_spacing
      // R2
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        us_tick_o |=> !us_tick_o);
    end
  endgenerate

endmodule

// File: rtl/usb_wake_detect.sv
module usb_wake_detect #(
  parameter int unsigned DET_CLKS = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic line_k_i,
  output logic wake_o
);

  localparam int unsigned DW = $clog2(DET_CLKS + 1);
  localparam logic [DW-1:0] LAST = DW'(DET_CLKS - 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          run;

  always_comb begin
    run    = armed_i && line_k_i;
    wake_o = run && (cnt_q == LAST);
    if (run && !wake_o) cnt_d = cnt_q + 1'b1;
    else                cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R10
  burst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_k_i |=> (cnt_q == '0));

endmodule

// File: rtl/usb_link_fsm.sv
module usb_link_fsm
  import usb_link_pkg::*;
#(
  parameter int unsigned US_PER_MS = 1000,
  parameter int unsigned RESET_MS  = 50,
  parameter int unsigned QUIET_MS  = 10,
  parameter int unsigned RESUME_MS = 21,
  parameter int unsigned EOP_US    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rst_req_i,
  input  logic       rsm_req_i,
  input  logic       sof_en_i,
  input  logic       wake_i,
  input  logic       us_tick_i,
  output logic       restart_o,
  output logic       detect_arm_o,
  output logic [1:0] line_o,
  output logic       frame_tick_o,
  output logic       suspended_o,
  output logic       traffic_ok_o
);

  localparam int unsigned RST_US   = RESET_MS * US_PER_MS;
  localparam int unsigned QUIET_US = QUIET_MS * US_PER_MS;
  localparam int unsigned RSM_US   = RESUME_MS * US_PER_MS;
  localparam int unsigned FRAME_US = US_PER_MS;
  localparam int unsigned M1 = (RST_US > RSM_US) ? RST_US : RSM_US;
  localparam int unsigned M2 = (M1 > QUIET_US) ? M1 : QUIET_US;
  localparam int unsigned MAX_US = (M2 > EOP_US) ? M2 : EOP_US;
  localparam int unsigned TW = $clog2(MAX_US + 1);

  link_st_e      state_q, state_d;
  logic [TW-1:0] tcnt_q, tcnt_d, limit;
  logic          hit, hit_frame;
  logic          sof_seen_q, sof_seen_d;
  logic          ftick_q, ftick_d;

  // Per-state duration in microseconds.
  always_comb begin
    unique case (state_q)
      ST_RST:                    limit = TW'(RST_US);
      ST_RST_QUIET, ST_RSM_QUIET: limit = TW'(QUIET_US);
      ST_RSM:                    limit = TW'(RSM_US);
      ST_RSM_EOP:                limit = TW'(EOP_US);
      default:                   limit = TW'(FRAME_US);
    endcase
    hit       = us_tick_i && (tcnt_q == limit - TW'(1));
    hit_frame = us_tick_i && (tcnt_q == TW'(FRAME_US - 1));
  end

  // Next state.
  always_comb begin
    state_d = state_q;
    if (rst_req_i) begin
      state_d = ST_RST;
    end else begin
      unique case (state_q)
        ST_SUSP:      if (rsm_req_i || wake_i) state_d = ST_RSM;
        ST_IDLE:      if (!sof_en_i) state_d = ST_SUSP;
        ST_RST:       if (hit) state_d = ST_RST_QUIET;
        ST_RST_QUIET: if (hit) state_d = sof_en_i ? ST_IDLE : ST_SUSP;
        ST_RSM:       if (hit) state_d = ST_RSM_EOP;
        ST_RSM_EOP:   if (hit) state_d = ST_RSM_QUIET;
        ST_RSM_QUIET: begin
          if (hit_frame && !(sof_seen_q || sof_en_i)) state_d = ST_SUSP;
          else if (hit) state_d = sof_en_i ? ST_IDLE : ST_SUSP;
        end
        default:      state_d = ST_SUSP;
      endcase
    end
  end

  // Phase timer, frame grace flag and frame tick.
  always_comb begin
    restart_o  = rst_req_i || (state_d != state_q);
    tcnt_d     = tcnt_q;
    if (restart_o) begin
      tcnt_d = '0;
    end else if (us_tick_i && (state_q != ST_SUSP)) begin
      if (state_q == ST_IDLE && hit) tcnt_d = '0;
      else                           tcnt_d = tcnt_q + 1'b1;
    end
    sof_seen_d = (state_q == ST_RSM_QUIET) ? (sof_seen_q || sof_en_i) : 1'b0;
    ftick_d    = (state_q == ST_IDLE) && hit && sof_en_i && !rst_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SUSP;
      tcnt_q     <= '0;
      sof_seen_q <= 1'b0;
      ftick_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      tcnt_q     <= tcnt_d;
      sof_seen_q <= sof_seen_d;
      ftick_q    <= ftick_d;
    end
  end

  // Output decode.
  always_comb begin
    unique case (state_q)
      ST_RST:     line_o = LINE_SE0;
      ST_RSM:     line_o = LINE_K;
      ST_RSM_EOP: line_o = LINE_EOP;
      default:    line_o = LINE_J;
    endcase
    suspended_o  = (state_q == ST_SUSP);
    detect_arm_o = suspended_o;
    traffic_ok_o = (state_q == ST_IDLE);
    frame_tick_o = ftick_q;
  end

  // R6
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (traffic_ok_o && !sof_en_i && !rst_req_i) |=> suspended_o);

  // R3
  rst_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (line_o == LINE_SE0));

  // R7
  rsm_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspended_o && rsm_req_i && !rst_req_i) |=> (line_o == LINE_K && !suspended_o));

  // R11
  traffic_j_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    traffic_ok_o |-> (line_o == LINE_J && !suspended_o));

  // R5
  tick_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick_o |-> traffic_ok_o);

  // R8
  eop_after_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o == LINE_EOP) |-> ($past(line_o) == LINE_K || $past(line_o) == LINE_EOP));

endmodule

// File: rtl/usb_host_link_seq.sv
module usb_host_link_seq #(
  parameter int unsigned CLK_PER_US = 48,
  parameter int unsigned US_PER_MS  = 1000,
  parameter int unsigned RESET_MS   = 50,
  parameter int unsigned QUIET_MS   = 10,
  parameter int unsigned RESUME_MS  = 21,
  parameter int unsigned EOP_US     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_reset_req_i,
  input  logic       resume_req_i,
  input  logic       sof_en_i,
  input  logic       remote_k_i,
  output logic [1:0] line_o,
  output logic       frame_tick_o,
  output logic       suspended_o,
  output logic       traffic_ok_o
);

  // 2.5 us rounded up to whole clocks.
  localparam int unsigned DET_CLKS = (5 * CLK_PER_US + 1) / 2;

  logic us_tick, restart, wake, arm;

  usb_us_prescaler #(.CLK_PER_US(CLK_PER_US)) u_prescaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .us_tick_o (us_tick)
  );

  usb_wake_detect #(.DET_CLKS(DET_CLKS)) u_wake_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .armed_i  (arm),
    .line_k_i (remote_k_i),
    .wake_o   (wake)
  );

  usb_link_fsm #(
    .US_PER_MS (US_PER_MS),
    .RESET_MS  (RESET_MS),
    .QUIET_MS  (QUIET_MS),
    .RESUME_MS (RESUME_MS),
    .EOP_US    (EOP_US)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_req_i    (bus_reset_req_i),
    .rsm_req_i    (resume_req_i),
    .sof_en_i     (sof_en_i),
    .wake_i       (wake),
    .us_tick_i    (us_tick),
    .restart_o    (restart),
    .detect_arm_o (arm),
    .line_o       (line_o),
    .frame_tick_o (frame_tick_o),
    .suspended_o  (suspended_o),
    .traffic_ok_o (traffic_ok_o)
  );

endmodule

// File: tb/usb_host_link_seq_bench.sv
module usb_host_link_seq_bench;

  localparam int CPU = 2;
  localparam int UPM = 20;
  localparam int RMS = 50;
  localparam int QMS = 10;
  localparam int SMS = 21;
  localparam int EUS = 2;

  function automatic int ms_cyc(input int ms);
    return ms * UPM * CPU;
  endfunction
  function automatic int det_cyc();
    return (5 * CPU + 1) / 2;
  endfunction

  localparam int L_J = 0, L_K = 1, L_SE0 = 2, L_EOP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0, rsm_req = 1'b0, sof_en = 1'b0, rk = 1'b0;
  logic [1:0] line;
  logic ftick, susp, tok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_host_link_seq #(
    .CLK_PER_US(CPU), .US_PER_MS(UPM), .RESET_MS(RMS),
    .QUIET_MS(QMS), .RESUME_MS(SMS), .EOP_US(EUS)
  ) u_usb_host_link_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_req_i(rst_req),
    .resume_req_i(rsm_req), .sof_en_i(sof_en), .remote_k_i(rk),
    .line_o(line), .frame_tick_o(ftick), .suspended_o(susp), .traffic_ok_o(tok)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_rst();
    rst_req = 1'b1; step(1); rst_req = 1'b0;
  endtask

  task automatic pulse_rsm();
    rsm_req = 1'b1; step(1); rsm_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ticks;
    void'($urandom(32'd20240));
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 suspended", susp, 1);
    chk("R1 line", line, L_J);
    chk("R1 traffic", tok, 0);
    chk("R1 tick", ftick, 0);

    // R10 short remote bursts ignored while suspended
    for (int i = 0; i < 8; i++) begin
      rk = 1'b1; step($urandom_range(det_cyc() - 1, 1));
      rk = 1'b0; step($urandom_range(5, 1));
      chk("R10 short burst stays suspended", susp, 1);
    end

    // R6 enable alone does not leave suspend
    sof_en = 1'b1; step(5);
    chk("R6 enable in suspend", susp, 1);

    // R2 / R4 bus reset then quiet then idle
    pulse_rst();
    chk("R2 SE0 start", line, L_SE0);
    step(ms_cyc(RMS) - 1);
    chk("R2 SE0 last cycle", line, L_SE0);
    step(1);
    chk("R4 J after reset", line, L_J);
    chk("R4 blocked", tok, 0);
    step(ms_cyc(QMS) - 1);
    chk("R4 still blocked", tok, 0);
    step(1);
    chk("R4 idle traffic", tok, 1);
    chk("R4 idle not suspended", susp, 0);

    // R5 frame tick timing
    step(ms_cyc(1) - 1);
    chk("R5 before tick", ftick, 0);
    step(1);
    chk("R5 tick", ftick, 1);
    step(1);
    chk("R5 tick one cycle", ftick, 0);
    step(ms_cyc(1) - 2);
    chk("R5 before second", ftick, 0);
    step(1);
    chk("R5 second tick", ftick, 1);

    // R11 random resume/remote-K noise in idle, R5 tick count
    ticks = 0;
    for (int c = 0; c < 10 * ms_cyc(1); c++) begin
      rsm_req = ($urandom_range(7, 0) == 0);
      rk = ($urandom_range(1, 0) == 1);
      step(1);
      if (ftick) ticks++;
      if (c % 37 == 0) begin
        chk("R11 traffic in idle", tok, 1);
        chk("R11 line J in idle", line, L_J);
      end
    end
    rsm_req = 1'b0; rk = 1'b0;
    chk("R5 tick count", ticks, 10);

    // R6 drop enable
    sof_en = 1'b0; step(1);
    chk("R6 suspended", susp, 1);
    chk("R6 traffic low", tok, 0);

    // R7 / R8 / R9 local resume with enable inside grace window
    pulse_rsm();
    chk("R7 suspend cleared", susp, 0);
    chk("R7 K", line, L_K);
    step(ms_cyc(SMS) - 1);
    chk("R7 K last", line, L_K);
    step(1);
    chk("R8 EOP", line, L_EOP);
    step(EUS * CPU - 1);
    chk("R8 EOP last", line, L_EOP);
    step(1);
    chk("R8 J quiet", line, L_J);
    step(10);
    sof_en = 1'b1;
    step(ms_cyc(QMS) - 11);
    chk("R8 quiet blocked", tok, 0);
    step(1);
    chk("R9 idle after quiet", tok, 1);

    // R9 resume with no enable: back to suspend after one frame
    sof_en = 1'b0; step(1);
    pulse_rsm();
    step(ms_cyc(SMS) + EUS * CPU);
    chk("R9 quiet entered", line, L_J);
    step(ms_cyc(1) - 1);
    chk("R9 not yet suspended", susp, 0);
    step(1);
    chk("R9 back to suspend", susp, 1);

    // R10 remote wake
    rk = 1'b1;
    step(det_cyc() - 1);
    chk("R10 before detect", susp, 1);
    step(1);
    chk("R10 host K", line, L_K);
    rk = 1'b0;
    step(ms_cyc(SMS) - 1);
    chk("R10 K full length", line, L_K);
    step(1);
    chk("R10 EOP after", line, L_EOP);

    // R3 reset beats resume, restart mid reset
    rst_req = 1'b1; rsm_req = 1'b1; step(1); rst_req = 1'b0; rsm_req = 1'b0;
    chk("R3 reset wins", line, L_SE0);
    step(1000);
    pulse_rst();
    step(ms_cyc(RMS) - 1);
    chk("R3 restart extends SE0", line, L_SE0);
    step(1);
    chk("R3 SE0 ends", line, L_J);
    step(ms_cyc(QMS) - 1);
    chk("R4 quiet no enable", susp, 0);
    step(1);
    chk("R4 suspend without enable", susp, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule